// File: doc/BRIEF.md
# Write-in-Progress Status Reporter

This block sits between the array read path and the host-facing data bus of a byte-wide non-volatile memory. It tells the host whether the internal program cycle is still running. While the write controller reports a cycle in progress, each read the host makes returns status instead of array contents:

- the top data bit is the complement of the top bit of the most recently loaded byte;
- the next bit changes value on every read;
- the low bits pass through from the array.

When the cycle ends, true array data flows through again. A separate ready/busy line is also provided. It is modelled as an output enable plus a level: it is pulled low while a cycle runs and released otherwise.

Reads travel as a stream. A read request carries the array byte on `rd_valid`/`rd_ready`, and the result leaves on `out_valid`/`out_ready` through a one-entry output register.

Back-pressure works as follows:

- A request is accepted only when `rd_valid` and `rd_ready` are both high.
- `rd_ready` is high when the output register is empty or is being drained in the same cycle.
- A result held with `out_ready` low keeps `out_valid` high and its data unchanged.

An active-low protect input blocks reads while it is low. It also removes any pending result and floats the data bus.

Top module: `wip_status`

## Requirements
- R1: With no program cycle in progress, an accepted read returns the array byte unchanged on `out_data` one cycle after acceptance.
- R2: During a program cycle, an accepted read returns the inverse of bit 7 of the last loaded byte on bit 7, and array bits 5:0 on bits 5:0.
- R3: During a program cycle, bit 6 of successive read results alternates on every accepted read.
- R4: The first read after the start of each new program cycle returns 1 on bit 6, whatever the toggle state at the end of the previous cycle.
- R5: `rdy_oe` goes high and `rdy_level` goes low one cycle after `wr_busy` rises. Both return to the released state (`rdy_oe` 0, `rdy_level` 1) one cycle after `wr_busy` falls.
- R6: Once the program cycle has ended, reads return true array data again on all bits, and bit 6 no longer toggles.
- R7: While `prot_n` is low, `rd_ready` and `data_oe` are 0 in the same cycle. A pending result is discarded at the next clock edge, and requests offered during that time produce no result and do not advance the toggle state.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` stays stable, `out_valid` stays high and `rd_ready` is 0.
- R9: After reset, `out_valid` is 0, `rdy_oe` is 0, `rdy_level` is 1 and `rd_ready` is 1.
- R10: The polled bit always reflects the byte from the most recent `wr_strobe`, even when several bytes are loaded within one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_n | input | 1 | Active-low read protect; low blocks reads and floats data |
| wr_busy | input | 1 | Program cycle in progress, from write controller |
| wr_strobe | input | 1 | One-cycle pulse: a byte was loaded |
| wr_data | input | 8 | Byte loaded with `wr_strobe` |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted this cycle |
| arr_data | input | 8 | Array byte carried with the read request |
| out_valid | output | 1 | Read result valid |
| out_ready | input | 1 | Host takes the read result |
| out_data | output | 8 | Read result |
| data_oe | output | 1 | Data bus drive enable |
| rdy_oe | output | 1 | Ready/busy line drive enable |
| rdy_level | output | 1 | Ready/busy line level (0 driven, 1 released) |

## Verification
A stale cycle flag shows at once on `rdy_oe` and on the next read. That read returns array bit 7 and bit 6 where status bits were expected, or status where data was expected. A toggle register that fails to reinitialise or to flip is visible on bit 6 within two reads of a cycle starting. A wrong captured byte appears on bit 7 on the first poll after the load. Output-register faults show as data that changes during a stall or as a result that survives protect.

// File: rtl/wip_stat_pkg.sv
package wip_stat_pkg;
  typedef enum logic [0:0] {
    RD_PASS = 1'b0,
    RD_POLL = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/wip_window.sv
module wip_window #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_busy,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_acc,
  output logic              busy_q,
  output logic              tog_q,
  output logic [DATA_W-1:0] last_q
);
  logic cycle_start;
  assign cycle_start = wr_busy && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tog_q  <= 1'b1;
      last_q <= '0;
    end else begin
      busy_q <= wr_busy;
      if (wr_strobe) last_q <= wr_data;
      if (cycle_start) tog_q <= 1'b1;
      else if (rd_acc && busy_q) tog_q <= ~tog_q;
    end
  end

  AST_TOG_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> tog_q); // R4
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && busy_q && wr_busy) |=> (tog_q != $past(tog_q))); // R3
  AST_TOG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !wr_busy) |=> $stable(tog_q)); // R6
endmodule

// File: rtl/wip_rdmux.sv
module wip_rdmux
  import wip_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_n,
  input  rd_mode_e          mode,
  input  logic [DATA_W-1:0] arr_data,
  input  logic [DATA_W-1:0] last_q,
  input  logic              tog_q,
  input  logic              rd_valid,
  output logic              rd_ready,
  output logic              rd_acc,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] next_word;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign status_word[i] = ~last_q[i];
    end else if (i == TOG_BIT) begin : g_tog
      assign status_word[i] = tog_q;
    end else begin : g_pass
      assign status_word[i] = arr_data[i];
    end
  end

  assign next_word = (mode == RD_POLL) ? status_word : arr_data;
  assign rd_ready  = prot_n && (!out_valid || out_ready);
  assign rd_acc    = rd_valid && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (!prot_n) begin
      out_valid <= 1'b0;
    end else if (rd_acc) begin
      out_valid <= 1'b1;
      out_data  <= next_word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && mode == RD_PASS) |=> (out_data == $past(arr_data))); // R1
  AST_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && mode == RD_POLL) |=> (out_data[POLL_BIT] != $past(last_q[POLL_BIT]))); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && prot_n) |=> (out_valid && $stable(out_data))); // R8
  AST_PROT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_n |=> !out_valid); // R7
endmodule

// File: rtl/wip_status.sv
module wip_status
  import wip_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_n,
  input  logic              wr_busy,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] arr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              data_oe,
  output logic              rdy_oe,
  output logic              rdy_level
);
  logic              busy_q;
  logic              tog_q;
  logic [DATA_W-1:0] last_q;
  logic              rd_acc;
  rd_mode_e          mode;

  assign mode = busy_q ? RD_POLL : RD_PASS;

  wip_window #(.DATA_W(DATA_W)) u_window (
    .clk(clk), .rst_n(rst_n), .wr_busy(wr_busy), .wr_strobe(wr_strobe),
    .wr_data(wr_data), .rd_acc(rd_acc), .busy_q(busy_q), .tog_q(tog_q),
    .last_q(last_q)
  );

  wip_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .clk(clk), .rst_n(rst_n), .prot_n(prot_n), .mode(mode),
    .arr_data(arr_data), .last_q(last_q), .tog_q(tog_q),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_acc(rd_acc),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );

  assign data_oe   = out_valid && prot_n;
  assign rdy_oe    = busy_q;
  assign rdy_level = !busy_q;

  AST_RDY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy) |=> (rdy_oe && !rdy_level)); // R5
  AST_RDY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_busy) |=> (!rdy_oe && rdy_level)); // R5
  AST_PROT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_n |-> (!data_oe && !rd_ready)); // R7
endmodule

// File: tb/wip_status_tb.sv
module wip_status_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prot_n = 1'b1;
  logic       wr_busy = 1'b0;
  logic       wr_strobe = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_valid = 1'b0;
  logic       rd_ready;
  logic [7:0] arr_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       data_oe, rdy_oe, rdy_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wip_status u_dut (
    .clk(clk), .rst_n(rst_n), .prot_n(prot_n), .wr_busy(wr_busy),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .arr_data(arr_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .data_oe(data_oe),
    .rdy_oe(rdy_oe), .rdy_level(rdy_level)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] got, output logic v);
    @(negedge clk);
    rd_valid = 1'b1;
    arr_data = a;
    @(negedge clk);
    rd_valid = 1'b0;
    got = out_data;
    v = out_valid;
  endtask

  task automatic load_byte(input logic [7:0] d);
    @(negedge clk);
    wr_strobe = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_strobe = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic v;
    logic exp_tog;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!out_valid && !rdy_oe && rdy_level && rd_ready, "R9",
          {out_valid, rdy_oe, rdy_level, rd_ready}, 4'b0011);
    rst_n = 1'b1;

    // R1 idle sweep
    for (int a = 0; a < 256; a++) begin
      do_read(8'(a), got, v);
      check(v && got == 8'(a), "R1", got, a);
    end

    // R5 rise
    @(negedge clk);
    wr_busy = 1'b1;
    @(negedge clk);
    check(rdy_oe && !rdy_level, "R5", {rdy_oe, rdy_level}, 2'b10);

    // R2 R3 R10 sweep of loaded bytes within one cycle
    exp_tog = 1'b1;
    for (int d = 0; d < 256; d++) begin
      load_byte(8'(d));
      do_read(8'(255 - d), got, v);
      check(v && got[7] == ~d[7] && got[5:0] == 6'(255 - d), "R2/R10",
            got, {~d[7], exp_tog, 6'(255 - d)});
      check(got[6] == exp_tog, "R3", got[6], exp_tog);
      exp_tog = ~exp_tog;
    end

    // R7 protect during busy: no result, toggle frozen
    @(negedge clk);
    prot_n = 1'b0;
    #1;
    check(!rd_ready && !data_oe, "R7", {rd_ready, data_oe}, 0);
    do_read(8'h3C, got, v);
    check(!v, "R7", v, 0);
    @(negedge clk);
    prot_n = 1'b1;
    do_read(8'h00, got, v);
    check(v && got[6] == exp_tog, "R7", got[6], exp_tog);
    exp_tog = ~exp_tog;

    // R5 fall, R6 true data after cycle, toggle stopped
    @(negedge clk);
    wr_busy = 1'b0;
    @(negedge clk);
    check(!rdy_oe && rdy_level, "R5", {rdy_oe, rdy_level}, 2'b01);
    for (int a = 0; a < 8; a++) begin
      do_read(8'(a * 37 + 64), got, v);
      check(v && got == 8'(a * 37 + 64), "R6", got, 8'(a * 37 + 64));
    end

    // R4 new cycles restart toggle at 1; leave with toggle at 0 first
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      wr_busy = 1'b1;
      load_byte(8'(c * 64));
      for (int r = 0; r <= c; r++) begin
        do_read(8'hA5, got, v);
        if (r == 0) check(got[6] == 1'b1, "R4", got[6], 1);
        check(got[6] == ((r % 2) == 0), "R3", got[6], ((r % 2) == 0));
      end
      @(negedge clk);
      wr_busy = 1'b0;
      @(negedge clk);
    end

    // R8 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    rd_valid = 1'b1;
    arr_data = 8'h5A;
    @(negedge clk);
    arr_data = 8'hC3;
    for (int k = 0; k < 3; k++) begin
      check(out_valid && out_data == 8'h5A && !rd_ready, "R8", out_data, 8'h5A);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    check(out_valid && out_data == 8'hC3, "R8", out_data, 8'hC3);

    // R7 pending result dropped by protect
    @(negedge clk);
    out_ready = 1'b0;
    rd_valid = 1'b1;
    arr_data = 8'h11;
    @(negedge clk);
    rd_valid = 1'b0;
    prot_n = 1'b0;
    @(negedge clk);
    check(!out_valid && !data_oe, "R7", out_valid, 0);
    prot_n = 1'b1;
    out_ready = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule